// File: doc/BRIEF.md
# Set-Associative Tag Directory

This block models the tag side of a set-associative cache. It keeps no data. It only decides, for each address it receives, whether that address would hit or miss. Each cycle it can take one address. It splits the address into a byte offset, a set number and a tag. It compares the tag against every way of the chosen set. On a miss it installs the tag, so a later access to the same block hits.

When a miss finds an empty way, the block fills the empty way with the lowest index by itself. When every way of the set already holds a block, the block raises a victim request carrying the set number. An external replacement unit answers in the same cycle with the way to overwrite. The registered result tells the replacement unit what happened: the set, the way touched and whether the access hit. The block also keeps running counts of accesses and misses. The default geometry is 8 ways, 64-byte blocks and 32 sets, which is 16 KiB.

Top module: `tagdir_top`

## Requirements
- R1: While reset is held, and in the cycle after it, res_valid is 0 and both counters read 0. Reset clears every valid bit, so the first access to any address afterwards misses, including one whose tag was resident before reset.
- R2: Address fields with the defaults are as follows: the byte offset is addr[5:0] and plays no part in the lookup, the set number is addr[10:6] and is reported on res_set, and the tag is addr[31:11]. Two addresses with the same tag but different sets are separate blocks.
- R3: An access hits only if a way of the indexed set holds the same tag and that way is valid. A stored tag in an invalid way never hits; after reset, address 0 misses.
- R4: On a miss where the set has an invalid way, the tag goes into the invalid way with the lowest index. vic_req stays 0 during such a miss.
- R5: On a miss where every way of the set is valid, vic_req is 1 in the cycle of the access and vic_set carries the set number. The tag goes into the way given on vic_way, and the tag it displaces misses when accessed later.
- R6: acc_cnt rises by 1 for every accepted access, and miss_cnt rises by 1 for every access that missed. Both new values are visible one cycle after the access.
- R7: An access presented with acc_valid = 1 produces exactly one result on the next cycle. res_valid is 0 in every cycle that follows a cycle with acc_valid = 0.
- R8: Each result is also the update sent to the replacement unit: res_hit is 1 for a hit, and res_way is the way that hit or the way that was filled.
- R9: An access in the cycle directly after a fill already sees the installed tag.
- R10: Configurations are rejected at elaboration unless the set and offset fields fit inside the address, the way count is at least 1, and the cache size divides evenly by both the block size and the set size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | ADDR_W | Access address |
| vic_req | output | 1 | Victim request (miss on a full set) |
| vic_set | output | SET_LG | Set number of the victim request |
| vic_way | input | WAY_W | Victim way returned in the same cycle |
| res_valid | output | 1 | Result strobe, one cycle after the access |
| res_hit | output | 1 | 1 = hit, 0 = miss |
| res_set | output | SET_LG | Set of the access (replacement update) |
| res_way | output | WAY_W | Way that hit or was filled |
| acc_cnt | output | CNT_W | Total accepted accesses |
| miss_cnt | output | CNT_W | Total misses |

## Verification
The bench goes after four corner cases.

- **Offset change:** an address that differs only in its offset bits must hit. A design that let offset bits into the tag or set would miss here.
- **Same tag, another set:** the same tag placed in a different set must miss. A design that got this wrong would report a false hit.
- **Full set:** after a set fills, a miss must raise the victim request and land in exactly the way given on vic_way. It must also evict the tag that was there. A design that kept searching for empty ways, or ignored the answer from the replacement unit, would place the tag wrongly, and a later access to the evicted tag would hit.
- **Reset and back-to-back access:** after reset, a previously resident tag must miss. An access made one cycle after a fill must hit. A design that let stale valid bits survive reset, or that delayed the write, would fail these checks.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;
   function automatic int idx_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/tagdir_addr_split.sv
module tagdir_addr_split #(
   parameter int ADDR_W = 32,
   parameter int BLK_LG = 6,
   parameter int SET_LG = 5,
   localparam int TAG_W = ADDR_W - BLK_LG - SET_LG
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [SET_LG-1:0] set_idx,
   output logic [TAG_W-1:0]  tag
);
   assign set_idx = addr[BLK_LG +: SET_LG];
   assign tag     = addr[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/tagdir_ways.sv
module tagdir_ways #(
   parameter int WAYS   = 8,
   parameter int SET_LG = 5,
   parameter int TAG_W  = 21,
   localparam int NSETS = 1 << SET_LG,
   localparam int WAY_W = tagdir_pkg::idx_bits(WAYS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [SET_LG-1:0] rd_set,
   input  logic [TAG_W-1:0]  rd_tag,
   output logic [WAYS-1:0]   hit_vec,
   output logic [WAYS-1:0]   valid_vec,
   input  logic              wr_en,
   input  logic [SET_LG-1:0] wr_set,
   input  logic [WAY_W-1:0]  wr_way,
   input  logic [TAG_W-1:0]  wr_tag
);
   logic [WAYS-1:0] vld [NSETS];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < NSETS; s++) vld[s] <= '0;
      end else if (wr_en) begin
         vld[wr_set][wr_way] <= 1'b1;
      end
   end

   assign valid_vec = vld[rd_set];

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [TAG_W-1:0] tags [NSETS];
      always_ff @(posedge clk) begin
         if (wr_en && (wr_way == WAY_W'(w))) tags[wr_set] <= wr_tag;
      end
      assign hit_vec[w] = valid_vec[w] && (tags[rd_set] == rd_tag);
   end

   // R3: a tag lives in at most one way of a set
   assert_hit_onehot_R3: assert property (@(posedge clk) disable iff (rst)
      $onehot0(hit_vec));
endmodule

// File: rtl/tagdir_fill_pick.sv
module tagdir_fill_pick #(
   parameter int WAYS = 8,
   localparam int WAY_W = tagdir_pkg::idx_bits(WAYS)
) (
   input  logic [WAYS-1:0]  valid_vec,
   output logic             has_free,
   output logic [WAY_W-1:0] free_way
);
   if (WAYS == 1) begin : g_direct
      assign has_free = ~valid_vec[0];
      assign free_way = '0;
   end else begin : g_assoc
      always_comb begin
         free_way = '0;
         for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_vec[w]) free_way = WAY_W'(w);
         end
      end
      assign has_free = ~&valid_vec;
   end
endmodule

// File: rtl/tagdir_top.sv
module tagdir_top #(
   parameter int ADDR_W = 32,
   parameter int BLK_LG = 6,
   parameter int SET_LG = 5,
   parameter int WAYS   = 8,
   parameter int CNT_W  = 64,
   localparam int WAY_W = tagdir_pkg::idx_bits(WAYS),
   localparam int TAG_W = ADDR_W - BLK_LG - SET_LG
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic              vic_req,
   output logic [SET_LG-1:0] vic_set,
   input  logic [WAY_W-1:0]  vic_way,
   output logic              res_valid,
   output logic              res_hit,
   output logic [SET_LG-1:0] res_set,
   output logic [WAY_W-1:0]  res_way,
   output logic [CNT_W-1:0]  acc_cnt,
   output logic [CNT_W-1:0]  miss_cnt
);
   localparam longint BLK_BYTES = longint'(1) << BLK_LG;
   localparam longint SET_BYTES = BLK_BYTES * WAYS;
   localparam longint CACHE_BYTES = SET_BYTES << SET_LG;

   // R10: configuration legality
   initial begin
      assert_cfg_legal_R10: assert (WAYS >= 1 && SET_LG >= 1 && BLK_LG >= 0 &&
                                    TAG_W >= 1 &&
                                    (CACHE_BYTES % BLK_BYTES) == 0 &&
                                    (CACHE_BYTES % SET_BYTES) == 0)
         else $fatal(1, "tagdir_top: illegal geometry");
   end

   logic [SET_LG-1:0] a_set;
   logic [TAG_W-1:0]  a_tag;
   logic [WAYS-1:0]   hit_vec, valid_vec;
   logic              has_free, any_hit;
   logic [WAY_W-1:0]  free_way, hit_way, fill_way;
   logic              do_fill;

   tagdir_addr_split #(.ADDR_W(ADDR_W), .BLK_LG(BLK_LG), .SET_LG(SET_LG)) u_split (
      .addr(acc_addr), .set_idx(a_set), .tag(a_tag));

   tagdir_ways #(.WAYS(WAYS), .SET_LG(SET_LG), .TAG_W(TAG_W)) u_ways (
      .clk(clk), .rst(rst), .rd_set(a_set), .rd_tag(a_tag),
      .hit_vec(hit_vec), .valid_vec(valid_vec),
      .wr_en(do_fill), .wr_set(a_set), .wr_way(fill_way), .wr_tag(a_tag));

   tagdir_fill_pick #(.WAYS(WAYS)) u_pick (
      .valid_vec(valid_vec), .has_free(has_free), .free_way(free_way));

   always_comb begin
      hit_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (hit_vec[w]) hit_way = WAY_W'(w);
      end
   end

   assign any_hit  = |hit_vec;
   assign do_fill  = acc_valid && !any_hit;
   assign vic_req  = do_fill && !has_free;
   assign vic_set  = a_set;
   assign fill_way = has_free ? free_way : vic_way;

   always_ff @(posedge clk) begin
      if (rst) begin
         res_valid <= 1'b0;
         res_hit   <= 1'b0;
         res_set   <= '0;
         res_way   <= '0;
         acc_cnt   <= '0;
         miss_cnt  <= '0;
      end else begin
         res_valid <= acc_valid;
         if (acc_valid) begin
            res_hit <= any_hit;
            res_set <= a_set;
            res_way <= any_hit ? hit_way : fill_way;
            acc_cnt <= acc_cnt + 1'b1;
            if (!any_hit) miss_cnt <= miss_cnt + 1'b1;
         end
      end
   end

   // R7: one result per access, none without one
   assert_res_follows_R7: assert property (@(posedge clk) disable iff (rst)
      acc_valid |=> res_valid);
   assert_no_spurious_R7: assert property (@(posedge clk) disable iff (rst)
      !acc_valid |=> !res_valid);
   // R6: counters step by one per access; misses never exceed accesses
   assert_cnt_step_R6: assert property (@(posedge clk) disable iff (rst)
      acc_valid |=> acc_cnt == $past(acc_cnt) + 1'b1);
   assert_miss_le_acc_R6: assert property (@(posedge clk) disable iff (rst)
      miss_cnt <= acc_cnt);
   // R5: victim way supplied must exist
   assert_vic_in_range_R5: assert property (@(posedge clk) disable iff (rst)
      vic_req |-> (int'(vic_way) < WAYS));
   // R4: a miss on a set with room never asks for a victim
   assert_free_no_vic_R4: assert property (@(posedge clk) disable iff (rst)
      (acc_valid && !(&valid_vec)) |-> !vic_req);
endmodule

// File: tb/tb_tagdir_top.sv
module tb_tagdir_top;
   logic        clk = 1'b0;
   logic        rst;
   logic        acc_valid;
   logic [31:0] acc_addr;
   logic        vic_req;
   logic [4:0]  vic_set;
   logic [2:0]  vic_way;
   logic        res_valid, res_hit;
   logic [4:0]  res_set;
   logic [2:0]  res_way;
   logic [63:0] acc_cnt, miss_cnt;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   always #4 clk = ~clk;

   tagdir_top dut (
      .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .vic_req(vic_req), .vic_set(vic_set), .vic_way(vic_way),
      .res_valid(res_valid), .res_hit(res_hit), .res_set(res_set),
      .res_way(res_way), .acc_cnt(acc_cnt), .miss_cnt(miss_cnt));

   // {addr, victim way, exp hit, exp way, exp victim request}
   localparam int NV = 16;
   localparam logic [39:0] VEC [NV] = '{
      {32'h000008C0, 3'd0, 1'b0, 3'd0, 1'b0},
      {32'h000008FF, 3'd0, 1'b1, 3'd0, 1'b0},
      {32'h00000900, 3'd0, 1'b0, 3'd0, 1'b0},
      {32'h000010C0, 3'd0, 1'b0, 3'd1, 1'b0},
      {32'h000018C0, 3'd0, 1'b0, 3'd2, 1'b0},
      {32'h000020C0, 3'd0, 1'b0, 3'd3, 1'b0},
      {32'h000028C0, 3'd0, 1'b0, 3'd4, 1'b0},
      {32'h000030C0, 3'd0, 1'b0, 3'd5, 1'b0},
      {32'h000038C0, 3'd0, 1'b0, 3'd6, 1'b0},
      {32'h000040C0, 3'd0, 1'b0, 3'd7, 1'b0},
      {32'h000028C0, 3'd0, 1'b1, 3'd4, 1'b0},
      {32'h000048C0, 3'd2, 1'b0, 3'd2, 1'b1},
      {32'h000018C0, 3'd6, 1'b0, 3'd6, 1'b1},
      {32'h000048C0, 3'd0, 1'b1, 3'd2, 1'b0},
      {32'h000038C0, 3'd0, 1'b0, 3'd0, 1'b1},
      {32'h000008C0, 3'd1, 1'b0, 3'd1, 1'b1}
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   // one access: drive at negedge, check victim request, check result next negedge
   task automatic access(input logic [31:0] a, input logic [2:0] vw,
                         input logic eh, input logic [2:0] ew, input logic eq,
                         input string req);
      acc_valid = 1'b1; acc_addr = a; vic_way = vw;
      #1;
      chk({req, " R5 vic_req"}, 64'(vic_req), 64'(eq));
      if (eq) chk("R5 vic_set", 64'(vic_set), 64'(a[10:6]));
      @(negedge clk);
      acc_valid = 1'b0;
      chk({req, " R7 res_valid"}, 64'(res_valid), 64'd1);
      chk({req, " R3 res_hit"}, 64'(res_hit), 64'(eh));
      chk({req, " R8 res_way"}, 64'(res_way), 64'(ew));
      chk({req, " R2 res_set"}, 64'(res_set), 64'(a[10:6]));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      rst = 1'b1; acc_valid = 1'b0; acc_addr = '0; vic_way = '0;
      repeat (3) @(negedge clk);
      // R1: state during reset
      chk("R1 res_valid in reset", 64'(res_valid), 64'd0);
      chk("R1 acc_cnt in reset", acc_cnt, 64'd0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 miss_cnt after reset", miss_cnt, 64'd0);
      chk("R1 res_valid after reset", 64'(res_valid), 64'd0);

      // table walk: R2 offset/set split, R4 lowest free fill, R5 victim fill, R8 update
      for (int i = 0; i < NV; i++) begin
         access(VEC[i][39:8], VEC[i][7:5], VEC[i][4], VEC[i][3:1], VEC[i][0],
                $sformatf("row%0d R4", i));
      end
      chk("R6 acc_cnt after table", acc_cnt, 64'd16);
      chk("R6 miss_cnt after table", miss_cnt, 64'd13);

      // R7: idle cycle yields no result, counters hold
      @(negedge clk);
      chk("R7 idle res_valid", 64'(res_valid), 64'd0);
      chk("R6 idle acc_cnt", acc_cnt, 64'd16);

      // R9: back-to-back miss then hit on a fresh set
      access(32'h70000040, 3'd5, 1'b0, 3'd0, 1'b0, "R9 first");
      access(32'h70000040, 3'd5, 1'b1, 3'd0, 1'b0, "R9 second");
      chk("R6 acc_cnt b2b", acc_cnt, 64'd18);
      chk("R6 miss_cnt b2b", miss_cnt, 64'd14);

      // R1: reset mid-run clears valid bits and counters
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R1 acc_cnt after mid reset", acc_cnt, 64'd0);
      chk("R1 res_valid after mid reset", 64'(res_valid), 64'd0);
      access(32'h000048C0, 3'd3, 1'b0, 3'd0, 1'b0, "R1 resident tag after reset");
      // R3: tag 0 in set 0 matches reset-time tag storage only if valid is ignored
      access(32'h00000000, 3'd3, 1'b0, 3'd0, 1'b0, "R3 addr zero");
      chk("R6 miss_cnt after reset", miss_cnt, 64'd2);
      summary();
   end
endmodule